// File: doc/BRIEF.md
# Ethernet MAC Clock Generator

This block derives the transmit and receive clocks for one Gigabit Ethernet MAC channel. On the transmit side one of three PLL clocks is picked and then divided by two 6-bit programmable dividers in series. The result is the internal reference clock. A fabric-supplied transmit clock may stand in for it. The chosen clock then passes through a clock gate before it leaves as the transmit clock. On the receive side the block chooses between a PHY clock arriving on a dedicated pin and one routed through the fabric. For local MAC loopback it can instead forward the internal reference clock. That clock is gated as well, to save power.

Software programs the block through two 32-bit control words: word 0 for transmit and word 1 for receive. The dividers accept a new divisor live, and the switch happens only on an output rising edge. The source multiplexers are plain combinational selects and can glitch. The gate behind a multiplexer must therefore be closed before its select changes, and reopened afterwards. Every gate brings its enable into its own clock domain through two flops. It then holds that enable in a latch that is open while the clock is low.

Top module: `eth_clk_gen`

## Requirements
- R1: After reset both `tx_clk_o` and `rx_clk_o` stay low, because every enable, select and divisor field resets to zero.
- R2: Word 0 holds the first divisor at bits [13:8] and the second at [25:20]. A field value of 0 acts as 1. The reference clock period equals the source period times both effective divisors.
- R3: A divider stage with divisor d ≥ 2 drives its output high for ceil(d/2) of its input periods and low for floor(d/2). With divisor 1 the stage passes its input through unchanged.
- R4: Word 0 bits [5:4] choose the PLL input. The values 0, 1 and 2 choose inputs 0, 1 and 2, and the value 3 also chooses input 2.
- R5: When word 0 bit [6] is 1, the fabric transmit clock feeds the transmit gate in place of the reference clock.
- R6: Word 0 bit [0] opens the transmit gate. While it is 0, `tx_clk_o` stays low.
- R7: A divisor written while a divider runs takes effect at that divider's next wrap. No output pulse is shorter than the shorter of the old and new phases.
- R8: Word 1 bit [4] chooses the PHY clock: 0 for the pin clock, 1 for the fabric clock. Word 1 bit [0] opens the receive gate, and while it is 0 `rx_clk_o` stays low.
- R9: When word 1 bit [5] is 1, `rx_clk_o` follows the internal reference clock. This holds whatever transmit word bits [6] and [0] say.
- R10: A mux field (word 0 bits [6:4], word 1 bits [5:4]) may change only when the matching enable is 0, both in the stored word and in the word being written. After this sequence the output resumes with the new source's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Control register clock |
| rst | input | 1 | Synchronous active-high reset, held across all clock domains |
| cfg_we | input | 1 | Write strobe for a control word |
| cfg_addr | input | 1 | Word select: 0 transmit, 1 receive |
| cfg_wdata | input | 32 | Control word value |
| pll_clk_i | input | 3 | The three PLL clocks |
| tx_clk_fab_i | input | 1 | Fabric-supplied transmit clock |
| rx_clk_pin_i | input | 1 | PHY receive clock on the dedicated pin |
| rx_clk_fab_i | input | 1 | PHY receive clock routed through fabric |
| tx_clk_o | output | 1 | Gated transmit clock |
| rx_clk_o | output | 1 | Gated receive clock |

## Verification
The assertions assume that software changes a source or loopback select only while the stored enable and the written enable are both 0. They also assume that reset is held long enough for every derived clock domain to see it. The bench keeps to these rules. Before any select change it writes the enable low and waits several output periods. It writes the new select with the enable still low, and reopens the gate only in a separate write. Divisors are the one thing it changes while a clock runs, since the dividers are built to accept that.

// File: rtl/eth_clk_pkg.sv
`timescale 1ns/1ps
package eth_clk_pkg;
    localparam int DIV_W  = 6;
    localparam int N_PLL  = 3;
    localparam int PSEL_W = 2;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic [5:0]        rsv_hi;
        div_t              div_b;      // [25:20]
        logic [5:0]        rsv_mid;
        div_t              div_a;      // [13:8]
        logic              rsv7;
        logic              ext_tx;     // [6]
        logic [PSEL_W-1:0] pll_sel;    // [5:4]
        logic [2:0]        rsv_lo;
        logic              en;         // [0]
    } tx_word_t;

    typedef struct packed {
        logic [25:0]       rsv_hi;
        logic              lpbk;       // [5]
        logic              fab_sel;    // [4]
        logic [2:0]        rsv_lo;
        logic              en;         // [0]
    } rx_word_t;

    function automatic div_t div_eff(div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    function automatic div_t div_hi(div_t d);
        return (d >> 1) + div_t'(d[0]);
    endfunction
endpackage

// File: rtl/ecg_divider.sv
`timescale 1ns/1ps
module ecg_divider
    import eth_clk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  div_t div_i,
    output logic clk_o
);
    div_t cnt_q, cur_q, nxt_cnt, nxt_cur;
    logic q_q, nxt_q, wrap;

    always_comb begin
        wrap    = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cur_q};
        nxt_cur = wrap ? div_eff(div_i) : cur_q;
        nxt_cnt = wrap ? '0 : cnt_q + 1'b1;
        nxt_q   = nxt_cnt < div_hi(nxt_cur);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            cur_q <= div_t'(1);
            q_q   <= 1'b0;
        end else begin
            cnt_q <= nxt_cnt;
            cur_q <= nxt_cur;
            q_q   <= nxt_q;
        end
    end

    assign clk_o = (cur_q == div_t'(1)) ? clk_i : q_q;

    AST_CNT_BELOW_DIV: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < cur_q);                                           // R2
    AST_SWAP_ON_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(cur_q) |-> cnt_q == '0);                         // R7
    AST_HIGH_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == '0 && cur_q != div_t'(1)) |-> q_q);             // R3
endmodule

// File: rtl/ecg_clk_gate.sv
`timescale 1ns/1ps
module ecg_clk_gate #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic clk_o
);
    logic [SYNC_N-1:0] sync_q;
    logic              en_lat;

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[SYNC_N-2:0], en_i};
    end

    always_latch begin
        if (!clk_i) en_lat = sync_q[SYNC_N-1];
    end

    assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/eth_clk_gen.sv
`timescale 1ns/1ps
module eth_clk_gen
    import eth_clk_pkg::*;
(
    input  logic             cfg_clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic [N_PLL-1:0] pll_clk_i,
    input  logic             tx_clk_fab_i,
    input  logic             rx_clk_pin_i,
    input  logic             rx_clk_fab_i,
    output logic             tx_clk_o,
    output logic             rx_clk_o
);
    localparam int N_STAGE = 2;

    tx_word_t tx_q, tx_wr;
    rx_word_t rx_q, rx_wr;

    assign tx_wr = tx_word_t'(cfg_wdata);
    assign rx_wr = rx_word_t'(cfg_wdata);

    always_ff @(posedge cfg_clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (cfg_we) begin
            if (!cfg_addr) tx_q <= tx_wr;
            else           rx_q <= rx_wr;
        end
    end

    // PLL source select; codes beyond the last input map to it
    logic [PSEL_W-1:0] src_idx;
    logic              stage_clk [N_STAGE+1];
    div_t              stage_div [N_STAGE];

    always_comb begin
        src_idx = (int'(tx_q.pll_sel) >= N_PLL) ? PSEL_W'(N_PLL-1) : tx_q.pll_sel;
        stage_clk[0] = pll_clk_i[src_idx];
    end

    assign stage_div[0] = tx_q.div_a;
    assign stage_div[1] = tx_q.div_b;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        ecg_divider u_div (
            .clk_i (stage_clk[s]),
            .rst_i (rst),
            .div_i (stage_div[s]),
            .clk_o (stage_clk[s+1])
        );
    end

    logic ref_clk, tx_pre, rx_phy, rx_pre;
    assign ref_clk = stage_clk[N_STAGE];
    assign tx_pre  = tx_q.ext_tx  ? tx_clk_fab_i : ref_clk;
    assign rx_phy  = rx_q.fab_sel ? rx_clk_fab_i : rx_clk_pin_i;
    assign rx_pre  = rx_q.lpbk    ? ref_clk      : rx_phy;

    ecg_clk_gate #(.SYNC_N(2)) u_tx_gate (
        .clk_i (tx_pre),
        .rst_i (rst),
        .en_i  (tx_q.en),
        .clk_o (tx_clk_o)
    );

    ecg_clk_gate #(.SYNC_N(2)) u_rx_gate (
        .clk_i (rx_pre),
        .rst_i (rst),
        .en_i  (rx_q.en),
        .clk_o (rx_clk_o)
    );

    AST_TX_MUX_GATED: assert property (@(posedge cfg_clk) disable iff (rst)
        (cfg_we && !cfg_addr && ({tx_wr.ext_tx, tx_wr.pll_sel} != {tx_q.ext_tx, tx_q.pll_sel}))
        |-> (!tx_q.en && !tx_wr.en));                              // R10
    AST_RX_MUX_GATED: assert property (@(posedge cfg_clk) disable iff (rst)
        (cfg_we && cfg_addr && ({rx_wr.lpbk, rx_wr.fab_sel} != {rx_q.lpbk, rx_q.fab_sel}))
        |-> (!rx_q.en && !rx_wr.en));                              // R10
endmodule

// File: tb/test_eth_clk_gen.sv
`timescale 1ns/1ps
module test_eth_clk_gen;
    localparam real CLK_PERIOD = 8.0;
    localparam real WDOG_NS    = 150000.0;
    localparam real TOL        = 0.01;

    logic        cfg_clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        p0 = 1'b0, p1 = 1'b0, p2 = 1'b0;
    logic        txf = 1'b0, rxp = 1'b0, rxf = 1'b0;
    logic        tx_clk, rx_clk;

    int checks = 0;
    int fails  = 0;

    real     pll_per [3] = '{10.0, 14.0, 6.0};
    bit      mon_on = 1'b0;
    realtime last_edge = -1.0;
    realtime min_pulse = 1.0e9;

    always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;
    always #5  p0  = ~p0;
    always #7  p1  = ~p1;
    always #3  p2  = ~p2;
    always #9  txf = ~txf;
    always #8  rxp = ~rxp;
    always #11 rxf = ~rxf;

    eth_clk_gen i_eth_clk_gen (
        .cfg_clk      (cfg_clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .pll_clk_i    ({p2, p1, p0}),
        .tx_clk_fab_i (txf),
        .rx_clk_pin_i (rxp),
        .rx_clk_fab_i (rxf),
        .tx_clk_o     (tx_clk),
        .rx_clk_o     (rx_clk)
    );

    always @(tx_clk) begin
        if (mon_on) begin
            if (last_edge >= 0.0 && ($realtime - last_edge) < min_pulse)
                min_pulse = $realtime - last_edge;
            last_edge = $realtime;
        end
    end

    function automatic logic [31:0] mk_tx(bit en, logic [1:0] sel, bit ext, int d0, int d1);
        return {6'd0, 6'(d1), 6'd0, 6'(d0), 1'b0, ext, sel, 3'b000, en};
    endfunction

    function automatic logic [31:0] mk_rx(bit en, bit fab, bit lp);
        return {26'd0, lp, fab, 3'b000, en};
    endfunction

    task automatic wr(input bit a, input logic [31:0] d);
        @(negedge cfg_clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge cfg_clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input real act, input real exp);
        checks++;
        if (act > exp + TOL || act < exp - TOL) begin
            fails++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
        end
    endtask

    task automatic measure(input bit rx, output real hi, output real per);
        realtime t0, t1, t2;
        if (rx) @(posedge rx_clk); else @(posedge tx_clk);
        t0 = $realtime;
        if (rx) @(negedge rx_clk); else @(negedge tx_clk);
        t1 = $realtime;
        if (rx) @(posedge rx_clk); else @(posedge tx_clk);
        t2 = $realtime;
        hi  = t1 - t0;
        per = t2 - t0;
    endtask

    task automatic count_high(input bit rx, input int ns, output int n);
        n = 0;
        for (int k = 0; k < ns; k++) begin
            #1;
            if (rx ? rx_clk : tx_clk) n++;
        end
    endtask

    initial begin
        #(WDOG_NS);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        real hi, per, e_per, e_hi, tp;
        int  n, d0e, d1e;

        repeat (12) @(posedge cfg_clk);
        #1 rst = 1'b0;

        // R1: both outputs quiet after reset
        count_high(1'b0, 300, n); chk("R1 tx low after reset", n, 0);
        count_high(1'b1, 300, n); chk("R1 rx low after reset", n, 0);

        // R8: pin PHY clock
        wr(1'b1, mk_rx(1, 0, 0));
        #400;
        measure(1'b1, hi, per);
        chk("R8 rx pin period", per, 16.0);
        chk("R8 rx pin high", hi, 8.0);

        // R2/R3: divisor sweep on PLL input 0, divisors changed live
        for (int d0 = 0; d0 <= 4; d0++) begin
            for (int d1 = 0; d1 <= 3; d1++) begin
                wr(1'b0, mk_tx(1, 2'd0, 0, d0, d1));
                #600;
                measure(1'b0, hi, per);
                d0e = (d0 == 0) ? 1 : d0;
                d1e = (d1 == 0) ? 1 : d1;
                e_per = d0e * d1e * 10.0;
                if (d1e >= 2)      e_hi = ((d1e + 1) / 2) * d0e * 10.0;
                else if (d0e >= 2) e_hi = ((d0e + 1) / 2) * 10.0;
                else               e_hi = 5.0;
                chk($sformatf("R2 period d0=%0d d1=%0d", d0, d1), per, e_per);
                chk($sformatf("R3 high d0=%0d d1=%0d", d0, d1), hi, e_hi);
            end
        end

        // R4/R10: PLL select with gate closed around the change
        for (int s = 1; s <= 3; s++) begin
            wr(1'b0, mk_tx(0, 2'(s - 1), 0, 3, 2));
            #400;
            wr(1'b0, mk_tx(0, 2'(s), 0, 3, 2));
            #100;
            wr(1'b0, mk_tx(1, 2'(s), 0, 3, 2));
            #800;
            measure(1'b0, hi, per);
            tp = pll_per[(s > 2) ? 2 : s];
            chk($sformatf("R4 R10 period sel=%0d", s), per, 6.0 * tp);
            chk($sformatf("R4 high sel=%0d", s), hi, 3.0 * tp);
        end

        // R5: fabric transmit clock, reference back on PLL 0 with 2x2
        wr(1'b0, mk_tx(0, 2'd3, 0, 3, 2));
        #400;
        wr(1'b0, mk_tx(0, 2'd0, 1, 2, 2));
        #100;
        wr(1'b0, mk_tx(1, 2'd0, 1, 2, 2));
        #400;
        measure(1'b0, hi, per);
        chk("R5 fabric tx period", per, 18.0);
        chk("R5 fabric tx high", hi, 9.0);

        // R9: loopback follows reference (40 ns), not the fabric tx clock
        wr(1'b1, mk_rx(0, 0, 0));
        #400;
        wr(1'b1, mk_rx(0, 0, 1));
        #100;
        wr(1'b1, mk_rx(1, 0, 1));
        #600;
        measure(1'b1, hi, per);
        chk("R9 loopback period", per, 40.0);
        chk("R9 loopback high", hi, 20.0);

        // R8: fabric PHY clock
        wr(1'b1, mk_rx(0, 0, 1));
        #400;
        wr(1'b1, mk_rx(0, 1, 0));
        #100;
        wr(1'b1, mk_rx(1, 1, 0));
        #400;
        measure(1'b1, hi, per);
        chk("R8 rx fabric period", per, 22.0);
        chk("R8 rx fabric high", hi, 11.0);

        // R6/R8: gates closed
        wr(1'b0, mk_tx(0, 2'd0, 1, 2, 2));
        wr(1'b1, mk_rx(0, 1, 0));
        #400;
        count_high(1'b0, 300, n); chk("R6 tx gated off", n, 0);
        count_high(1'b1, 300, n); chk("R8 rx gated off", n, 0);

        // R9: loopback runs while transmit gate is closed
        wr(1'b1, mk_rx(0, 0, 1));
        #100;
        wr(1'b1, mk_rx(1, 0, 1));
        #600;
        measure(1'b1, hi, per);
        chk("R9 loopback with tx off", per, 40.0);

        // R7: live divisor change, 2x3 -> 2x5
        wr(1'b0, mk_tx(0, 2'd0, 0, 2, 3));
        #100;
        wr(1'b0, mk_tx(1, 2'd0, 0, 2, 3));
        #600;
        mon_on = 1'b1;
        #300;
        wr(1'b0, mk_tx(1, 2'd0, 0, 2, 5));
        #800;
        mon_on = 1'b0;
        chk("R7 min pulse >= 20", (min_pulse >= 20.0 - TOL) ? 1.0 : 0.0, 1.0);
        measure(1'b0, hi, per);
        chk("R7 new period", per, 100.0);
        chk("R7 new high", hi, 60.0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule